// File: doc/BRIEF.md
# Undo-Log Ordering Memory Controller

This block sits between a cache and a byte-addressable persistent memory and gives software all-or-nothing durable regions without software logging. Inside a region opened by a begin request, the first store to each line makes the controller write the line's previous value, together with the line address, as one record in a reserved log area. The cache delivers that old value on a store hit. On a store miss the controller takes it from the fill it reads from memory.

A store is acknowledged as soon as its log record sits in the controller's write queue. A later writeback of that line is held inside the controller until memory has acknowledged the log record as persistent. Reads of a line whose writeback is still queued are answered from the queue. An end request waits until every queued write is persistent. It then writes an all-zero commit record that empties the log, and it answers only once that record is persistent.

The cache side sends one request at a time with a valid/ready handshake. Each accepted request gets exactly one response pulse. The memory side accepts one write or read per cycle. It acknowledges writes in issue order and returns reads in issue order.

Top module: `ulog_mc`

## Requirements
- R1: After reset, req_ready is high and rsp_valid, log_ovf, mem_wr_valid and mem_rd_valid are low.
- R2: req_op codes are 0 read, 1 store-miss fill, 2 store-hit log (req_data carries the line's old value), 3 writeback, 4 region begin and 5 region end. Every accepted request produces exactly one rsp_valid pulse. For codes 0 and 1, rsp_data carries the line's current value.
- R3: The memory write of a writeback is not issued while a log record for the same line is issued but not yet acknowledged by mem_wr_done.
- R4: Inside a region, the first code 1 or code 2 request to a line writes exactly one log record. Later code 1 or 2 requests to that line in the same region write none.
- R5: The n-th record of a region (counting from 0) is written to address LOG_BASE+n. Its mem_wr_data holds the line address in the upper AW bits and the old value in the lower DW bits.
- R6: A code 1 request inside a region logs the value that the fill read returned from memory.
- R7: A read or fill of a line whose writeback is queued but not yet acknowledged returns the writeback data, not the memory contents.
- R8: An end request waits until all queued writes are acknowledged, then writes an all-zero record to COMMIT_ADDR, and only after that record is acknowledged does it respond. The next region's first record goes to LOG_BASE again.
- R9: When LOG_SLOTS distinct lines are already logged in the region, a request that would log a new line writes no record and sets log_ovf. log_ovf stays set until the next begin request, which clears it.
- R10: Outside a region, code 1 and code 2 requests write no log record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Cache request present |
| req_ready | output | 1 | Controller takes the request this cycle |
| req_op | input | 3 | Request code (see R2) |
| req_addr | input | AW | Line address |
| req_data | input | DW | Old line value (code 2) or writeback data (code 3) |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | DW | Line value for codes 0 and 1, zero otherwise |
| log_ovf | output | 1 | Log area filled within the current region |
| mem_wr_valid | output | 1 | Memory write issue |
| mem_wr_addr | output | AW | Memory write address |
| mem_wr_data | output | AW+DW | Write record (data writes carry zero upper bits) |
| mem_wr_done | input | 1 | Oldest outstanding write is persistent |
| mem_rd_valid | output | 1 | Memory read issue |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_ret | input | 1 | Read data valid |
| mem_rd_data | input | DW | Read data |

## Verification
The assertions take three things as given. Memory never raises mem_wr_done with no write outstanding. Data line addresses stay below COMMIT_ADDR, so they never alias the log or commit words. The cache sends all of a region's writebacks before its end request. The bench's memory model acknowledges writes strictly in order after a fixed delay and applies the contents only at acknowledge. It answers one read at a time. All stimulus uses data addresses well below the log area, which keeps the inputs inside these assumptions. A long write delay keeps log records outstanding long enough that writeback stalls and queue forwarding are actually exercised.

// File: rtl/ulog_mc_pkg.sv
package ulog_mc_pkg;
  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_FILL  = 3'd1,
    OP_LOG   = 3'd2,
    OP_WB    = 3'd3,
    OP_BEGIN = 3'd4,
    OP_END   = 3'd5
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_EXEC,
    S_RDW,
    S_DRAIN,
    S_CMTW
  } st_e;
endpackage

// File: rtl/ulog_wq.sv
// In-order queue of writes issued to memory and not yet persistent.
// DEPTH must be a power of two, at least 2.
module ulog_wq #(
  parameter int AW    = 8,
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic          push_log,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic [AW-1:0] q_addr,
  output logic          log_hit,
  output logic          fwd_hit,
  output logic [DW-1:0] fwd_data,
  output logic          full,
  output logic          empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic [AW-1:0] e_addr [DEPTH];
  logic          e_log  [DEPTH];
  logic [DW-1:0] e_data [DEPTH];
  logic [PW-1:0] head, tail;
  logic [CW-1:0] cnt;
  logic [PW-1:0] head_n, tail_n;
  logic [CW-1:0] cnt_n;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  always_comb begin
    head_n = pop  ? head + 1'b1 : head;
    tail_n = push ? tail + 1'b1 : tail;
    cnt_n  = cnt + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cnt  <= '0;
    end else begin
      head <= head_n;
      tail <= tail_n;
      cnt  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      e_addr[tail] <= push_addr;
      e_log[tail]  <= push_log;
      e_data[tail] <= push_data;
    end
  end

  // Oldest to newest, so the newest matching writeback wins.
  always_comb begin
    logic [PW-1:0] idx;
    log_hit  = 1'b0;
    fwd_hit  = 1'b0;
    fwd_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = head + PW'(k);
      if (CW'(k) < cnt && e_addr[idx] == q_addr) begin
        if (e_log[idx]) begin
          log_hit = 1'b1;
        end else begin
          fwd_hit  = 1'b1;
          fwd_data = e_data[idx];
        end
      end
    end
  end

  AST_WQ_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop)); // R3
  AST_WQ_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R8
endmodule

// File: rtl/ulog_set.sv
// Lines already logged in the current region; the count doubles as log head.
module ulog_set #(
  parameter int AW    = 8,
  parameter int SLOTS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ins,
  input  logic [AW-1:0] q_addr,
  output logic          hit,
  output logic          full,
  output logic [$clog2(SLOTS+1)-1:0] used
);
  localparam int CW = $clog2(SLOTS + 1);

  logic [AW-1:0] slot [SLOTS];
  logic [CW-1:0] cnt, cnt_n;

  assign used = cnt;
  assign full = (cnt == CW'(SLOTS));

  always_comb begin
    cnt_n = cnt;
    if (clr)      cnt_n = '0;
    else if (ins) cnt_n = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end

  always_ff @(posedge clk) begin
    if (ins && !full) slot[cnt[CW-1:0] % SLOTS] <= q_addr;
  end

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (CW'(i) < cnt && slot[i] == q_addr) hit = 1'b1;
    end
  end

  AST_SET_NO_DUP: assert property (@(posedge clk) disable iff (!rst_n)
    ins |-> (!hit && !full)); // R4
endmodule

// File: rtl/ulog_mc.sv
module ulog_mc
  import ulog_mc_pkg::*;
#(
  parameter int          AW          = 8,
  parameter int          DW          = 16,
  parameter int          WQ_DEPTH    = 4,
  parameter int          LOG_SLOTS   = 4,
  parameter logic [7:0]  LOG_BASE    = 8'hC0,
  parameter logic [7:0]  COMMIT_ADDR = 8'hBF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [2:0]       req_op,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_data,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic             log_ovf,
  output logic             mem_wr_valid,
  output logic [AW-1:0]    mem_wr_addr,
  output logic [AW+DW-1:0] mem_wr_data,
  input  logic             mem_wr_done,
  output logic             mem_rd_valid,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic             mem_rd_ret,
  input  logic [DW-1:0]    mem_rd_data
);
  localparam int RW = AW + DW;
  localparam int SCW = $clog2(LOG_SLOTS + 1);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  st_e           st, st_n;
  op_e           cur_op, cur_op_n;
  logic [AW-1:0] cur_addr, cur_addr_n;
  logic [DW-1:0] cur_data, cur_data_n;
  logic          in_rgn, in_rgn_n, ovf, ovf_n;
  logic          rsp_v, rsp_v_n;
  logic [DW-1:0] rsp_d, rsp_d_n;
  logic          mw_v, mw_v_n, mw_data, mw_data_n;
  logic [AW-1:0] mw_a, mw_a_n;
  logic [RW-1:0] mw_d, mw_d_n;
  logic          mr_v, mr_v_n;
  logic [AW-1:0] mr_a, mr_a_n;

  logic          push, push_log;
  logic [AW-1:0] push_addr;
  logic [DW-1:0] push_data;
  logic          wq_log_hit, wq_fwd_hit, wq_full, wq_empty;
  logic [DW-1:0] wq_fwd_data;
  logic          set_clr, set_ins, set_hit, set_full;
  logic [SCW-1:0] set_used;
  logic [AW-1:0] log_ptr;
  logic          have_d, log_req;
  logic [DW-1:0] got_d, log_old;

  ulog_wq #(.AW(AW), .DW(DW), .DEPTH(WQ_DEPTH)) u_wq (
    .clk(clk), .rst_n(rst_i), .push(push), .push_addr(push_addr),
    .push_log(push_log), .push_data(push_data), .pop(mem_wr_done),
    .q_addr(cur_addr), .log_hit(wq_log_hit), .fwd_hit(wq_fwd_hit),
    .fwd_data(wq_fwd_data), .full(wq_full), .empty(wq_empty)
  );

  ulog_set #(.AW(AW), .SLOTS(LOG_SLOTS)) u_set (
    .clk(clk), .rst_n(rst_i), .clr(set_clr), .ins(set_ins),
    .q_addr(cur_addr), .hit(set_hit), .full(set_full), .used(set_used)
  );

  assign log_ptr   = LOG_BASE + AW'(set_used);
  assign req_ready = (st == S_IDLE) && !wq_full;

  always_comb begin
    st_n = st; cur_op_n = cur_op; cur_addr_n = cur_addr; cur_data_n = cur_data;
    in_rgn_n = in_rgn; ovf_n = ovf;
    rsp_v_n = 1'b0; rsp_d_n = '0;
    mw_v_n = 1'b0; mw_data_n = 1'b0; mw_a_n = mw_a; mw_d_n = mw_d;
    mr_v_n = 1'b0; mr_a_n = mr_a;
    push = 1'b0; push_log = 1'b0; push_addr = cur_addr; push_data = '0;
    set_clr = 1'b0; set_ins = 1'b0;
    have_d = 1'b0; got_d = '0; log_req = 1'b0; log_old = cur_data;
    case (st)
      S_IDLE: if (req_valid && req_ready) begin
        cur_op_n = op_e'(req_op); cur_addr_n = req_addr; cur_data_n = req_data;
        st_n = S_EXEC;
      end
      S_EXEC: case (cur_op)
        OP_READ, OP_FILL: begin
          if (wq_fwd_hit) begin
            have_d = 1'b1; got_d = wq_fwd_data;
          end else begin
            mr_v_n = 1'b1; mr_a_n = cur_addr; st_n = S_RDW;
          end
        end
        OP_LOG: begin
          log_req = in_rgn && !set_hit;
          rsp_v_n = 1'b1; st_n = S_IDLE;
        end
        OP_WB: if (!wq_log_hit) begin
          mw_v_n = 1'b1; mw_data_n = 1'b1; mw_a_n = cur_addr;
          mw_d_n = {{AW{1'b0}}, cur_data};
          push = 1'b1; push_data = cur_data;
          rsp_v_n = 1'b1; st_n = S_IDLE;
        end
        OP_BEGIN: begin
          in_rgn_n = 1'b1; set_clr = 1'b1; ovf_n = 1'b0;
          rsp_v_n = 1'b1; st_n = S_IDLE;
        end
        OP_END: st_n = S_DRAIN;
        default: begin
          rsp_v_n = 1'b1; st_n = S_IDLE;
        end
      endcase
      S_RDW: if (mem_rd_ret) begin
        have_d = 1'b1; got_d = mem_rd_data;
      end
      S_DRAIN: if (wq_empty) begin
        mw_v_n = 1'b1; mw_a_n = COMMIT_ADDR; mw_d_n = '0;
        push = 1'b1; push_log = 1'b1; push_addr = COMMIT_ADDR;
        st_n = S_CMTW;
      end
      S_CMTW: if (wq_empty) begin
        rsp_v_n = 1'b1; in_rgn_n = 1'b0; set_clr = 1'b1; st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
    if (have_d) begin
      rsp_v_n = 1'b1; rsp_d_n = got_d; st_n = S_IDLE;
      log_req = (cur_op == OP_FILL) && in_rgn && !set_hit;
      log_old = got_d;
    end
    if (log_req) begin
      if (set_full) begin
        ovf_n = 1'b1;
      end else begin
        mw_v_n = 1'b1; mw_a_n = log_ptr; mw_d_n = {cur_addr, log_old};
        push = 1'b1; push_log = 1'b1; push_addr = cur_addr;
        set_ins = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st <= S_IDLE; cur_op <= OP_READ; cur_addr <= '0; cur_data <= '0;
      in_rgn <= 1'b0; ovf <= 1'b0; rsp_v <= 1'b0; rsp_d <= '0;
      mw_v <= 1'b0; mw_data <= 1'b0; mw_a <= '0; mw_d <= '0;
      mr_v <= 1'b0; mr_a <= '0;
    end else begin
      st <= st_n; cur_op <= cur_op_n; cur_addr <= cur_addr_n; cur_data <= cur_data_n;
      in_rgn <= in_rgn_n; ovf <= ovf_n; rsp_v <= rsp_v_n; rsp_d <= rsp_d_n;
      mw_v <= mw_v_n; mw_data <= mw_data_n; mw_a <= mw_a_n; mw_d <= mw_d_n;
      mr_v <= mr_v_n; mr_a <= mr_a_n;
    end
  end

  assign rsp_valid    = rsp_v;
  assign rsp_data     = rsp_d;
  assign log_ovf      = ovf;
  assign mem_wr_valid = mw_v;
  assign mem_wr_addr  = mw_a;
  assign mem_wr_data  = mw_d;
  assign mem_rd_valid = mr_v;
  assign mem_rd_addr  = mr_a;

  AST_LOG_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_i)
    (mw_v && mw_data) |-> !wq_log_hit); // R3
  AST_END_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_i)
    (rsp_v && $past(st) == S_CMTW) |-> (wq_empty && !in_rgn)); // R8
  AST_ONE_ISSUE: assert property (@(posedge clk) disable iff (!rst_i)
    !(mw_v && mr_v)); // R2
  AST_OVF_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(ovf) |-> !mw_v); // R9
endmodule

// File: tb/ulog_mc_bench.sv
module ulog_mc_bench;
  localparam int AW = 8, DW = 16, RW = 24, WLAT = 12;
  localparam logic [7:0] LBASE = 8'hC0, CADDR = 8'hBF;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, req_valid, req_ready, rsp_valid, log_ovf;
  logic [2:0] req_op;
  logic [AW-1:0] req_addr, mem_wr_addr, mem_rd_addr;
  logic [DW-1:0] req_data, rsp_data, mem_rd_data;
  logic mem_wr_valid, mem_wr_done, mem_rd_valid, mem_rd_ret;
  logic [RW-1:0] mem_wr_data;

  ulog_mc u_ulog_mc (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .log_ovf(log_ovf),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_done(mem_wr_done), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rd_ret(mem_rd_ret), .mem_rd_data(mem_rd_data)
  );

  int checks = 0, errors = 0, cyc = 0;
  function automatic logic [DW-1:0] init_val(input logic [7:0] a);
    return {8'hA5 ^ a, a};
  endfunction

  // memory model: contents change only when a write is acknowledged
  logic [RW-1:0] mem [256];
  logic [7:0]    pa [16];
  logic [RW-1:0] pd [16];
  int pdue [16];
  int ph = 0, pn = 0, log_cnt = 0, rd_cnt = 0;
  logic [7:0] rd_a, last_log_addr;

  always @(posedge clk) begin
    cyc = cyc + 1;
    mem_wr_done <= 1'b0;
    mem_rd_ret  <= 1'b0;
    if (rst_n && mem_wr_valid) begin
      if (mem_wr_addr < CADDR) begin
        checks = checks + 1;
        for (int i = 0; i < pn; i++) begin
          if (pa[(ph+i)%16] >= LBASE && pd[(ph+i)%16][RW-1:DW] == mem_wr_addr) begin
            errors = errors + 1;
            $display("FAIL R3 data write to %h issued with log pending: act 1 exp 0", mem_wr_addr);
          end
        end
      end
      if (mem_wr_addr >= LBASE) begin
        log_cnt = log_cnt + 1;
        last_log_addr = mem_wr_addr;
      end
      pa[(ph+pn)%16] = mem_wr_addr;
      pd[(ph+pn)%16] = mem_wr_data;
      pdue[(ph+pn)%16] = cyc + WLAT;
      pn = pn + 1;
    end
    if (pn > 0 && cyc >= pdue[ph]) begin
      mem[pa[ph]] = pd[ph];
      mem_wr_done <= 1'b1;
      ph = (ph + 1) % 16;
      pn = pn - 1;
    end
    if (rst_n && mem_rd_valid) begin
      rd_a = mem_rd_addr;
      rd_cnt = 3;
    end else if (rd_cnt > 0) begin
      rd_cnt = rd_cnt - 1;
      if (rd_cnt == 0) begin
        mem_rd_ret  <= 1'b1;
        mem_rd_data <= mem[rd_a][DW-1:0];
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s act %h exp %h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic [2:0] op, input logic [7:0] a,
                        input logic [15:0] d, output logic [15:0] r);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = a; req_data = d;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    r = rsp_data;
  endtask

  // {op, addr, data, check-data, expected data, expected log count}
  localparam logic [47:0] VEC [8] = '{
    {3'd2, 8'h10, 16'h1111, 1'b0, 16'h0000, 4'd1},
    {3'd2, 8'h10, 16'h2222, 1'b0, 16'h0000, 4'd1},
    {3'd1, 8'h20, 16'h0000, 1'b1, 16'h8520, 4'd2},
    {3'd0, 8'h30, 16'h0000, 1'b1, 16'h9530, 4'd2},
    {3'd3, 8'h10, 16'hAAAA, 1'b0, 16'h0000, 4'd2},
    {3'd0, 8'h10, 16'h0000, 1'b1, 16'hAAAA, 4'd2},
    {3'd1, 8'h20, 16'h0000, 1'b1, 16'h8520, 4'd2},
    {3'd3, 8'h20, 16'hBBBB, 1'b0, 16'h0000, 4'd2}
  };

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors = errors + 1;
    $display("FAIL watchdog: act hung exp done");
    finish_run();
  end

  initial begin
    logic [15:0] r;
    int t0;
    for (int i = 0; i < 256; i++) mem[i] = {8'h00, init_val(8'(i))};
    mem[CADDR] = 24'hFFFFFF;
    rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0; req_data = '0;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 ready", 32'(req_ready), 1);
    check("R1 rsp_valid", 32'(rsp_valid), 0);
    check("R1 ovf", 32'(log_ovf), 0);
    check("R1 mem strobes", 32'({mem_wr_valid, mem_rd_valid}), 0);

    // R10: no logging outside a region
    do_req(3'd2, 8'h05, 16'h1234, r);
    do_req(3'd1, 8'h06, 16'h0000, r);
    check("R10 fill data", 32'(r), 32'(init_val(8'h06)));
    repeat (2) @(negedge clk);
    check("R10 log count", log_cnt, 0);

    // table: R2 R4 R6 R7 within one region
    do_req(3'd4, 8'h00, 16'h0000, r);
    for (int v = 0; v < 8; v++) begin
      do_req(VEC[v][47:45], VEC[v][44:37], VEC[v][36:21], r);
      if (VEC[v][20]) check($sformatf("R2 R6 R7 vec %0d data", v), 32'(r), 32'(VEC[v][19:4]));
      repeat (2) @(negedge clk);
      check($sformatf("R4 vec %0d log count", v), log_cnt, 32'(VEC[v][3:0]));
    end

    // R8: end drains, commits, then responds
    do_req(3'd5, 8'h00, 16'h0000, r);
    check("R8 queue drained at end", pn, 0);
    check("R8 commit record", 32'(mem[CADDR]), 0);
    check("R8 data persisted", 32'(mem[8'h10][15:0]), 32'h0000AAAA);
    check("R5 record 0", 32'(mem[LBASE]), 32'h101111);
    check("R5 R6 record 1", 32'(mem[LBASE + 8'd1]), 32'h208520);

    // R3 stall, R8 head reset, R9 overflow
    do_req(3'd4, 8'h00, 16'h0000, r);
    do_req(3'd2, 8'h40, 16'h4444, r);
    repeat (2) @(negedge clk);
    check("R8 head back at base", 32'(last_log_addr), 32'(LBASE));
    t0 = cyc;
    do_req(3'd3, 8'h40, 16'hCCCC, r);
    check("R3 writeback waited for log ack", 32'(cyc - t0 >= WLAT - 2), 1);
    for (int k = 1; k < 4; k++) do_req(3'd2, 8'h40 + 8'(k), 16'h0000, r);
    repeat (2) @(negedge clk);
    check("R9 before overflow", 32'(log_ovf), 0);
    t0 = log_cnt;
    do_req(3'd2, 8'h44, 16'h0000, r);
    repeat (2) @(negedge clk);
    check("R9 ovf set", 32'(log_ovf), 1);
    check("R9 no record written", log_cnt, t0);
    do_req(3'd5, 8'h00, 16'h0000, r);
    check("R9 ovf held to begin", 32'(log_ovf), 1);
    do_req(3'd4, 8'h00, 16'h0000, r);
    @(negedge clk);
    check("R9 ovf cleared by begin", 32'(log_ovf), 0);
    do_req(3'd5, 8'h00, 16'h0000, r);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule